// File: doc/BRIEF.md
# Sequential Seven-Operand Carry-Save Reducer

This block takes seven unsigned N-bit operands and turns them into three numbers whose sum equals the sum of the seven. The only arithmetic it uses is the 3-to-2 compressor: a row of independent one-bit full adders. Its delay is one full-adder delay whatever the width. Four dependent compressions do the reduction. The first folds operands one to three into a pair (a1, a2), and the second folds operands four to six into (b1, b2). The third folds a2, b2 and operand seven into (c1, c2). The last folds a1, b1 and c1 into (d1, d2). The three results are y1 = d1, y2 = d2 and y3 = c2.

A small control unit runs the compressions over several clock cycles. With one shared compressor (the default), the four operations take four consecutive cycles. With two compressors, the first two operations share one cycle, so the run takes three. Registers hold the partial results. Multiplexers in front of the compressor select its operands from a step counter. The final carry-propagate addition of the three results is left to the block that consumes them.

The user pulses `start` with the operands present and holds them until `done`. Then it reads y1..y3, which stay put until the next accepted start.

Top module: `csa7to3_seq`

## Requirements
- R1: When `done` is high, y1 + y2 + y3 equals the arithmetic sum of x1..x7, provided the operands were held since the accepted start.
- R2: `start` is accepted while the block is idle. `done` goes high 4 clock edges after the accepting edge when NUM_CSA = 1, and 3 edges after it when NUM_CSA = 2.
- R3: `done` is high for exactly one cycle per accepted start.
- R4: While the block is idle, y1, y2 and y3 do not change, even if x1..x7 change.
- R5: `start` is ignored while a run is in progress. The run's latency and result are unchanged, and no extra `done` follows.
- R6: Synchronous active-high `reset` clears y1..y3 to zero, drops `done` and returns the control unit to idle, aborting any run in progress.
- R7: The third compression starts only in the cycle after the second, and the fourth only in the cycle after the third. This ordering puts both a-pair and b-pair before c, and c before d.
- R8: All outputs are N+3 bits wide, with operands zero-extended. With every operand all-ones, the reduced sum is exactly 7·(2^N − 1), with no bit lost.
- R9: No cycle issues more compressions than NUM_CSA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reset | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a reduction when idle |
| x1 | input | N | Operand 1 |
| x2 | input | N | Operand 2 |
| x3 | input | N | Operand 3 |
| x4 | input | N | Operand 4 |
| x5 | input | N | Operand 5 |
| x6 | input | N | Operand 6 |
| x7 | input | N | Operand 7 |
| y1 | output | N+3 | Result d1 |
| y2 | output | N+3 | Result d2 |
| y3 | output | N+3 | Result c2 |
| done | output | 1 | One-cycle pulse when y1..y3 are valid |

## Verification
On every cycle, the assertions check the following:
- the operation ordering;
- that no cycle issues more compressions than there are compressors;
- that `done` is a single-cycle pulse following the last step;
- that a busy counter advances regardless of `start`;
- that outputs are frozen while idle;
- that the three outputs sum to the operands whenever `done` is high.

Only the bench's scenarios can show the following:
- the exact latency seen at the ports for both compressor counts, side by side;
- that a restart request in mid-run produces no second pulse;
- that a reset in mid-run aborts the run with cleared outputs;
- that the all-ones case keeps its top bits.

// File: rtl/csa7_pkg.sv
package csa7_pkg;
  localparam int NUM_OPS = 4;   // compressions per reduction
  localparam int STEP_W  = 3;   // wide enough for steps 0..NUM_OPS

  // number of the final step for a given compressor count
  function automatic int last_step(input int ncsa);
    return (ncsa >= 2) ? NUM_OPS - 1 : NUM_OPS;
  endfunction
endpackage

// File: rtl/csa3.sv
module csa3 #(
  parameter int W = 11
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  logic [W-1:0] maj;

  // one full adder per bit position, no ripple between positions
  assign sum   = a ^ b ^ c;
  assign maj   = (a & b) | (a & c) | (b & c);
  assign carry = maj << 1;
endmodule

// File: rtl/csa7_ctrl.sv
module csa7_ctrl
  import csa7_pkg::*;
#(
  parameter int NUM_CSA = 1
) (
  input  logic                 clk,
  input  logic                 reset,
  input  logic                 start,
  output logic [NUM_OPS-1:0]   op_en,
  output logic                 busy,
  output logic                 done
);
  localparam int LAST = last_step(NUM_CSA);

  logic [STEP_W-1:0] step;

  assign busy = (step != '0);

  always_ff @(posedge clk) begin
    if (reset) begin
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= (step == STEP_W'(LAST));
      if (step == '0) begin
        if (start) step <= STEP_W'(1);
      end else if (step == STEP_W'(LAST)) begin
        step <= '0;
      end else begin
        step <= step + STEP_W'(1);
      end
    end
  end

  generate
    if (NUM_CSA >= 2) begin : g_dual
      always_comb begin
        op_en = '0;
        case (step)
          STEP_W'(1): op_en = 4'b0011;
          STEP_W'(2): op_en = 4'b0100;
          STEP_W'(3): op_en = 4'b1000;
          default:    op_en = '0;
        endcase
      end
    end else begin : g_single
      always_comb begin
        op_en = '0;
        case (step)
          STEP_W'(1): op_en = 4'b0001;
          STEP_W'(2): op_en = 4'b0010;
          STEP_W'(3): op_en = 4'b0100;
          STEP_W'(4): op_en = 4'b1000;
          default:    op_en = '0;
        endcase
      end
    end
  endgenerate

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (reset)
    done |=> !done); // R3
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (reset)
    done |-> $past(step == STEP_W'(LAST))); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (reset)
    (busy && step != STEP_W'(LAST)) |=> (step == $past(step) + STEP_W'(1))); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    reset |=> (step == '0 && !done)); // R6
endmodule

// File: rtl/csa7to3_seq.sv
module csa7to3_seq
  import csa7_pkg::*;
#(
  parameter int N       = 8,
  parameter int NUM_CSA = 1,
  localparam int W      = N + 3
) (
  input  logic         clk,
  input  logic         reset,
  input  logic         start,
  input  logic [N-1:0] x1,
  input  logic [N-1:0] x2,
  input  logic [N-1:0] x3,
  input  logic [N-1:0] x4,
  input  logic [N-1:0] x5,
  input  logic [N-1:0] x6,
  input  logic [N-1:0] x7,
  output logic [W-1:0] y1,
  output logic [W-1:0] y2,
  output logic [W-1:0] y3,
  output logic         done
);
  localparam int SW = W + 2;

  logic [NUM_OPS-1:0] op_en;
  logic               busy;
  logic [W-1:0]       a1, a2, b1, b2, c1;
  logic [W-1:0]       in_p, in_q, in_r;
  logic [W-1:0]       s0, k0, bs, bk;

  csa7_ctrl #(.NUM_CSA(NUM_CSA)) u_ctrl (
    .clk(clk), .reset(reset), .start(start),
    .op_en(op_en), .busy(busy), .done(done)
  );

  // operand selection for the shared compressor
  always_comb begin
    in_p = '0;
    in_q = '0;
    in_r = '0;
    if (op_en[0]) begin
      in_p = W'(x1); in_q = W'(x2); in_r = W'(x3);
    end else if (op_en[1]) begin
      in_p = W'(x4); in_q = W'(x5); in_r = W'(x6);
    end else if (op_en[2]) begin
      in_p = a2; in_q = b2; in_r = W'(x7);
    end else if (op_en[3]) begin
      in_p = a1; in_q = b1; in_r = c1;
    end
  end

  csa3 #(.W(W)) u_csa0 (.a(in_p), .b(in_q), .c(in_r), .sum(s0), .carry(k0));

  generate
    if (NUM_CSA >= 2) begin : g_two
      csa3 #(.W(W)) u_csa1 (
        .a(W'(x4)), .b(W'(x5)), .c(W'(x6)), .sum(bs), .carry(bk)
      );
    end else begin : g_one
      assign bs = s0;
      assign bk = k0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (reset) begin
      a1 <= '0; a2 <= '0; b1 <= '0; b2 <= '0; c1 <= '0;
      y1 <= '0; y2 <= '0; y3 <= '0;
    end else begin
      if (op_en[0]) begin a1 <= s0; a2 <= k0; end
      if (op_en[1]) begin b1 <= bs; b2 <= bk; end
      if (op_en[2]) begin c1 <= s0; y3 <= k0; end
      if (op_en[3]) begin y1 <= s0; y2 <= k0; end
    end
  end

  AST_OPS_PER_CYCLE: assert property (@(posedge clk) disable iff (reset)
    $countones(op_en) <= NUM_CSA); // R9
  AST_OP3_ORDER: assert property (@(posedge clk) disable iff (reset)
    op_en[2] |-> $past(op_en[1])); // R7
  AST_OP4_ORDER: assert property (@(posedge clk) disable iff (reset)
    op_en[3] |-> $past(op_en[2])); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (reset)
    !busy |=> ($stable(y1) && $stable(y2) && $stable(y3))); // R4
  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (reset)
    done |-> (SW'(y1) + SW'(y2) + SW'(y3) ==
              SW'(x1) + SW'(x2) + SW'(x3) + SW'(x4) + SW'(x5) + SW'(x6) + SW'(x7))); // R1
endmodule

// File: tb/sim_csa7to3_seq.sv
module sim_csa7to3_seq;
  localparam int N = 8;
  localparam int W = N + 3;

  logic clk = 1'b0;
  logic reset = 1'b1;
  logic start = 1'b0;
  logic [N-1:0] x [7];
  logic [W-1:0] ya1, ya2, ya3, yb1, yb2, yb3;
  logic done0, done1;
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  csa7to3_seq #(.N(N), .NUM_CSA(1)) u0 (
    .clk(clk), .reset(reset), .start(start),
    .x1(x[0]), .x2(x[1]), .x3(x[2]), .x4(x[3]), .x5(x[4]), .x6(x[5]), .x7(x[6]),
    .y1(ya1), .y2(ya2), .y3(ya3), .done(done0));

  csa7to3_seq #(.N(N), .NUM_CSA(2)) u1 (
    .clk(clk), .reset(reset), .start(start),
    .x1(x[0]), .x2(x[1]), .x3(x[2]), .x4(x[3]), .x5(x[4]), .x6(x[5]), .x7(x[6]),
    .y1(yb1), .y2(yb2), .y3(yb3), .done(done1));

  localparam logic [N-1:0] TV [8][7] = '{
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF},
    '{8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80},
    '{8'h55, 8'hAA, 8'h55, 8'hAA, 8'h55, 8'hAA, 8'h55},
    '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE},
    '{8'hFF, 8'h01, 8'hFF, 8'h01, 8'hFF, 8'h01, 8'hFF},
    '{8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80}
  };

  function automatic int sum_a();
    return int'(ya1) + int'(ya2) + int'(ya3);
  endfunction
  function automatic int sum_b();
    return int'(yb1) + int'(yb2) + int'(yb3);
  endfunction
  function automatic int ref_sum();
    int s = 0;
    for (int i = 0; i < 7; i++) s += int'(x[i]);
    return s;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      summary();
      $finish;
    end
  end

  // one reduction on both instances; optional restart request mid-run
  task automatic run(input bit glitch);
    int lat0 = 0, lat1 = 0, p0 = 0, p1 = 0, expv;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    expv = ref_sum();
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (done0) begin
        p0++;
        if (lat0 == 0) lat0 = k;
        check(sum_a() == expv, "R1 sum one-CSA", sum_a(), expv);
      end
      if (done1) begin
        p1++;
        if (lat1 == 0) lat1 = k;
        check(sum_b() == expv, "R1 sum two-CSA", sum_b(), expv);
      end
      start = (glitch && k == 2);
    end
    start = 1'b0;
    check(lat0 == 4, "R2/R7/R9 latency one-CSA", lat0, 4);
    check(lat1 == 3, "R2/R7/R9 latency two-CSA", lat1, 3);
    check(p0 == 1 && p1 == 1, glitch ? "R5 single done despite restart" : "R3 done width",
          p0 + p1, 2);
  endtask

  initial begin
    for (int i = 0; i < 7; i++) x[i] = '0;
    repeat (3) @(negedge clk);
    // R6 reset state
    check(!done0 && !done1, "R6 done after reset", int'(done0) + int'(done1), 0);
    check(sum_a() == 0 && sum_b() == 0, "R6 outputs after reset", sum_a() + sum_b(), 0);
    reset = 1'b0;

    // table walk
    for (int v = 0; v < 8; v++) begin
      for (int i = 0; i < 7; i++) x[i] = TV[v][i];
      run(1'b0);
    end

    // R8 all-ones, top bits kept
    for (int i = 0; i < 7; i++) x[i] = '1;
    run(1'b0);
    check(sum_a() == 7 * 255, "R8 all-ones one-CSA", sum_a(), 7 * 255);
    check(sum_b() == 7 * 255, "R8 all-ones two-CSA", sum_b(), 7 * 255);

    // R4 outputs hold while idle with changing operands
    for (int i = 0; i < 7; i++) x[i] = 8'h3C;
    repeat (4) @(negedge clk);
    check(sum_a() == 7 * 255, "R4 hold one-CSA", sum_a(), 7 * 255);
    check(sum_b() == 7 * 255, "R4 hold two-CSA", sum_b(), 7 * 255);

    // R5 start while busy
    for (int i = 0; i < 7; i++) x[i] = N'(8'h11 * (i + 1));
    run(1'b1);
    check(sum_a() == ref_sum(), "R5 result after ignored start", sum_a(), ref_sum());

    // random operand sets
    for (int v = 0; v < 20; v++) begin
      for (int i = 0; i < 7; i++) x[i] = N'($urandom);
      run(1'b0);
    end

    // R6 reset in mid-run aborts
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    reset = 1'b1;
    @(negedge clk);
    reset = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (done0 || done1) seen++;
      end
      check(seen == 0, "R6 no done after abort", seen, 0);
    end
    check(sum_a() == 0 && sum_b() == 0, "R6 outputs cleared by abort", sum_a() + sum_b(), 0);

    // back to normal operation after abort
    for (int i = 0; i < 7; i++) x[i] = N'(i * 37 + 5);
    run(1'b0);

    summary();
    $finish;
  end
endmodule